// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for nine-bit words. Its write port and its read port run on separate clocks, which may be unrelated or may be the same clock. Each port is gated by two enables. The write side pushes a word on a rising write-clock edge when its enables allow it and the buffer is not full. The read side pops the oldest word into a registered output on a rising read-clock edge when its enables allow it and the buffer is not empty. An active-low output enable releases the data output to high impedance.

Four active-low status flags report the fill level: empty, full, almost-empty and almost-full. The two almost thresholds are held in an offset register. The second write-enable pin has two possible roles, and its level while reset is held fixes which one applies. High makes it a plain second write enable. Low puts the block in load mode. In load mode, holding that pin low turns write cycles into offset loads from the data input and turns read cycles into offset read-backs on the data output.

Pointers cross between the clock domains as Gray codes through two-flop synchronisers. Full and almost-full are derived in the write domain. Empty and almost-empty are derived in the read domain. The depth is a power of two set by a parameter.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high, the level of `wr_en2_ld` selects the port mode: 1 gives dual-enable mode and 0 gives load mode. The mode then stays fixed until the next reset.
- R2: In dual-enable mode, a word is stored on a rising `wr_clk` edge only when `wr_en1_n`=0, `wr_en2_ld`=1 and `full_n`=1. Any other combination stores nothing.
- R3: A word is taken on a rising `rd_clk` edge only when `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1, with load access not selected. Words come out in the order they were written, and each appears on `dout` after the read edge that takes it.
- R4: In load mode, a write cycle with `wr_en1_n`=0 and `wr_en2_ld`=0 copies `din[ADDR_W-1:0]` into the offset register and stores no FIFO word. Successive loads alternate between the almost-empty offset and the almost-full offset, starting with almost-empty.
- R5: In load mode, a read cycle with both read enables low and `wr_en2_ld`=0 puts the current offset on `dout[ADDR_W-1:0]`, with the upper bits 0, and leaves the FIFO contents unchanged. Successive read-backs alternate between the two offsets, starting with almost-empty.
- R6: `empty_n` is 0 when the FIFO holds no words, and `full_n` is 0 when it holds 2^ADDR_W words. A write while full stores nothing. A read while empty leaves `dout` unchanged.
- R7: `almost_empty_n` is 0 exactly when the word count is at or below the almost-empty offset. `almost_full_n` is 0 exactly when the free space is at or below the almost-full offset.
- R8: Reset (synchronous, active high, held in both clock domains) clears both pointers and `dout`, drives `empty_n`=0 and `full_n`=1, sets both offsets to 7 and points both offset selectors at almost-empty.
- R9: With `oe_n`=1, `dout` is high impedance. The output enable changes neither the stored data nor the output register.
- R10: Each Gray pointer changes by at most one bit per clock, and neither domain ever sees more than 2^ADDR_W words in the FIFO.
- R11: With unrelated clocks, writes and reads that overlap in time deliver every word exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset, held across both clocks |
| din | input | 9 | Write data, or offset value in a load cycle |
| wr_en1_n | input | 1 | Active-low primary write enable |
| wr_en2_ld | input | 1 | Second write enable (dual mode) or active-low offset-access select (load mode) |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable for `dout` |
| dout | output | 9 | Registered read data or offset read-back; high impedance when disabled |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| full_n | output | 1 | Active-low full flag (write domain) |
| almost_empty_n | output | 1 | Active-low almost-empty flag (read domain) |
| almost_full_n | output | 1 | Active-low almost-full flag (write domain) |

## Verification
The assertions check four things on every cycle. Each Gray pointer changes by at most one bit per edge. Neither domain's count ever goes past the depth. Empty always implies almost-empty, and full always implies almost-full. The port mode does not change after reset. Only the bench scenarios can show the rest: the exact flag thresholds at every fill level for both the default and the loaded offsets, the order of the offset selector, the first-in first-out data order under overlapping traffic on unrelated clocks, that gated and load cycles store no word, and the high-impedance output.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int DATA_W = 9;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_LOAD = 1'b1
    } port_mode_e;

    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int AW = 6,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW     = 6,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1_n,
    input  logic          en2_ld,
    input  logic [AW-1:0] ofs_din,
    input  logic [AW:0]   rgray_s,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          almost_full_n,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] ONE     = {{AW{1'b0}}, 1'b1};

    port_mode_e  mode;
    ofs_sel_e    ld_sel;
    logic [AW:0] wbin, wbin_nx, rbin_s, used, free;
    logic        ofs_load;

    always_comb begin
        for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign used          = wbin - rbin_s;
    assign free          = DEPTH_V - used;
    assign full_n        = (used != DEPTH_V);
    assign almost_full_n = !(free <= {1'b0, af_ofs});
    assign ofs_load      = !en1_n && (mode == MODE_LOAD) && !en2_ld;
    assign wr_fire       = !en1_n && en2_ld && full_n;
    assign wbin_nx       = wbin + ONE;
    assign waddr         = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= en2_ld ? MODE_DUAL : MODE_LOAD;
            wbin   <= '0;
            wgray  <= '0;
            ae_ofs <= AW'(AE_DEF);
            af_ofs <= AW'(AF_DEF);
            ld_sel <= SEL_EMPTY_OFS;
        end else begin
            if (wr_fire) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (ofs_load) begin
                if (ld_sel == SEL_EMPTY_OFS) ae_ofs <= ofs_din;
                else                         af_ofs <= ofs_din;
                ld_sel <= (ld_sel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
            end
        end
    end

    assert_mode_locked_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode));
    assert_wgray_step_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    assert_wr_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_V);
    assert_full_implies_af_R7: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !almost_full_n);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en1_n,
    input  logic              en2_n,
    input  logic              ld_pin,
    input  logic [AW:0]       wgray_s,
    input  logic [AW-1:0]     ae_ofs,
    input  logic [AW-1:0]     af_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rgray,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] ONE     = {{AW{1'b0}}, 1'b1};
    localparam int          PAD     = DATA_W - AW;

    port_mode_e  mode;
    ofs_sel_e    rb_sel;
    logic [AW:0] rbin, rbin_nx, wbin_s, used;
    logic        rd_req, ofs_read, rd_fire;

    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign used           = wbin_s - rbin;
    assign empty_n        = (used != '0);
    assign almost_empty_n = !(used <= {1'b0, ae_ofs});
    assign rd_req         = !en1_n && !en2_n;
    assign ofs_read       = rd_req && (mode == MODE_LOAD) && !ld_pin;
    assign rd_fire        = rd_req && !ofs_read && empty_n;
    assign rbin_nx        = rbin + ONE;
    assign raddr          = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= ld_pin ? MODE_DUAL : MODE_LOAD;
            rbin   <= '0;
            rgray  <= '0;
            q      <= '0;
            rb_sel <= SEL_EMPTY_OFS;
        end else if (ofs_read) begin
            q      <= {{PAD{1'b0}}, (rb_sel == SEL_EMPTY_OFS) ? ae_ofs : af_ofs};
            rb_sel <= (rb_sel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
        end else if (rd_fire) begin
            q     <= mem_rdata;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    assert_rd_mode_locked_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode));
    assert_rgray_step_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
    assert_rd_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_V);
    assert_empty_implies_ae_R7: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !almost_empty_n);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
    logic [DATA_W-1:0] mem_rdata, q;
    logic              wr_fire;

    dcf_wr_ctrl #(.AW(ADDR_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
        .clk(wr_clk), .rst(rst), .en1_n(wr_en1_n), .en2_ld(wr_en2_ld),
        .ofs_din(din[ADDR_W-1:0]), .rgray_s(rgray_s), .wr_fire(wr_fire),
        .waddr(waddr), .wgray(wgray), .full_n(full_n),
        .almost_full_n(almost_full_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcf_sync2 #(.W(ADDR_W + 1)) u_w2r (
        .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    dcf_sync2 #(.W(ADDR_W + 1)) u_r2w (
        .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    dcf_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcf_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
        .ld_pin(wr_en2_ld), .wgray_s(wgray_s), .ae_ofs(ae_ofs),
        .af_ofs(af_ofs), .mem_rdata(mem_rdata), .raddr(raddr),
        .rgray(rgray), .q(q), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n)
    );

    assign dout = oe_n ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic       wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic [8:0] din = '0;
    logic       wen1 = 1'b1, wen2 = 1'b1, ren1 = 1'b1, ren2 = 1'b1, oe_n = 1'b0;
    tri1  [8:0] dout;
    logic       empty_n, full_n, ae_n, af_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;
    logic [8:0] model[$];

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcfifo_pflag #(.ADDR_W(AW)) u_dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst(rst), .din(din),
        .wr_en1_n(wen1), .wr_en2_ld(wen2), .rd_en1_n(ren1), .rd_en2_n(ren2),
        .oe_n(oe_n), .dout(dout), .empty_n(empty_n), .full_n(full_n),
        .almost_empty_n(ae_n), .almost_full_n(af_n)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset(input logic mode_pin);
        rst = 1'b1; wen1 = 1'b1; ren1 = 1'b1; ren2 = 1'b1; wen2 = mode_pin;
        repeat (10) @(negedge wclk);
        rst = 1'b0; wen2 = 1'b1;
        settle();
    endtask

    task automatic wr_word(input logic [8:0] d);
        @(negedge wclk); wen1 = 1'b0; wen2 = 1'b1; din = d;
        @(negedge wclk); wen1 = 1'b1;
    endtask

    task automatic rd_word(output logic [8:0] d);
        @(negedge rclk); ren1 = 1'b0; ren2 = 1'b0;
        @(negedge rclk); ren1 = 1'b1; ren2 = 1'b1;
        d = dout;
    endtask

    task automatic ld_ofs(input logic [8:0] v);
        @(negedge wclk); wen1 = 1'b0; wen2 = 1'b0; din = v;
        @(negedge wclk); wen1 = 1'b1; wen2 = 1'b1;
    endtask

    task automatic rb_ofs(output logic [8:0] d);
        @(negedge rclk); wen2 = 1'b0; ren1 = 1'b0; ren2 = 1'b0;
        @(negedge rclk); wen2 = 1'b1; ren1 = 1'b1; ren2 = 1'b1;
        d = dout;
    endtask

    task automatic chk_flags(input int n, input int aeo, input int afo);
        chk("R6 empty", {8'd0, empty_n}, {8'd0, n != 0});
        chk("R6 full", {8'd0, full_n}, {8'd0, n != DEPTH});
        chk("R7 almost_empty", {8'd0, ae_n}, {8'd0, !(n <= aeo)});
        chk("R7 almost_full", {8'd0, af_n}, {8'd0, !((DEPTH - n) <= afo)});
    endtask

    task automatic fill_drain(input int aeo, input int afo, input int seed);
        logic [8:0] d;
        for (int n = 1; n <= DEPTH; n++) begin
            d = 9'((n * 37 + seed) & 9'h1FF);
            wr_word(d); model.push_back(d);
            settle(); chk_flags(n, aeo, afo);
        end
        wr_word(9'h1AA);
        settle(); chk_flags(DEPTH, aeo, afo);
        for (int n = DEPTH - 1; n >= 0; n--) begin
            rd_word(d);
            chk("R3 fifo order", d, model.pop_front());
            settle(); chk_flags(n, aeo, afo);
        end
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] d, last;
        do_reset(1'b1);
        // R8: reset state in dual-enable mode
        chk("R8 dout reset", dout, 9'h000);
        chk_flags(0, 7, 7);

        // R2: gated writes store nothing
        @(negedge wclk); wen1 = 1'b0; wen2 = 1'b0; din = 9'h055;
        @(negedge wclk); wen1 = 1'b1; wen2 = 1'b1;
        settle(); chk("R2 en2 low blocks", {8'd0, empty_n}, 9'd0);
        @(negedge wclk); wen1 = 1'b1; wen2 = 1'b1; din = 9'h056;
        @(negedge wclk);
        settle(); chk("R2 en1 high blocks", {8'd0, empty_n}, 9'd0);

        // R6 R7 R3 with default offsets, including write while full
        fill_drain(7, 7, 5);
        last = dout;
        rd_word(d);
        chk("R6 read while empty", d, last);

        // R3: a single read enable does not pop
        wr_word(9'h0A5); settle();
        @(negedge rclk); ren1 = 1'b0; ren2 = 1'b1;
        @(negedge rclk); ren1 = 1'b1;
        settle();
        chk("R3 one enable no pop", {8'd0, empty_n}, 9'd1);
        chk("R3 one enable dout", dout, last);
        rd_word(d);
        chk("R3 pop", d, 9'h0A5);

        // R9: output enable
        oe_n = 1'b1; #1;
        chk("R9 high impedance", dout, 9'h1FF);
        oe_n = 1'b0; #1;
        chk("R9 value restored", dout, 9'h0A5);

        // R11: overlapping traffic on unrelated clocks
        fork
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge wclk);
                    while (!full_n) @(negedge wclk);
                    wen1 = 1'b0; wen2 = 1'b1; din = 9'((k * 53 + 11) & 9'h1FF);
                    @(negedge wclk); wen1 = 1'b1;
                end
            end
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge rclk);
                    while (!empty_n) @(negedge rclk);
                    ren1 = 1'b0; ren2 = 1'b0;
                    @(negedge rclk); ren1 = 1'b1; ren2 = 1'b1;
                    chk("R11 concurrent order", dout, 9'((k * 53 + 11) & 9'h1FF));
                end
            end
        join
        settle(); chk("R11 empty after", {8'd0, empty_n}, 9'd0);

        // R1: load mode chosen by a low pin during reset
        do_reset(1'b0);
        chk_flags(0, 7, 7);
        rb_ofs(d); chk("R8 R5 default ae offset", d, 9'd7);
        rb_ofs(d); chk("R8 R5 default af offset", d, 9'd7);
        ld_ofs(9'h1E3);
        ld_ofs(9'h005);
        settle();
        chk("R4 load stores no word", {8'd0, empty_n}, 9'd0);
        rb_ofs(d); chk("R5 R4 ae offset", d, 9'd3);
        rb_ofs(d); chk("R5 R4 af offset", d, 9'd5);
        chk_flags(0, 3, 5);

        // R5: read-back on a full FIFO does not pop
        for (int n = 0; n < DEPTH; n++) begin
            d = 9'((n * 29 + 100) & 9'h1FF);
            wr_word(d); model.push_back(d);
        end
        settle();
        rb_ofs(d); chk("R5 readback while full", d, 9'd3);
        settle(); chk_flags(DEPTH, 3, 5);
        for (int n = DEPTH - 1; n >= 0; n--) begin
            rd_word(d);
            chk("R5 R3 data after readback", d, model.pop_front());
        end
        rb_ofs(d); chk("R5 selector order", d, 9'd5);
        settle();

        // R7 R6 sweep with the loaded offsets
        fill_drain(3, 5, 77);

        // R1: the pin is a load select, not a write enable, after reset
        ld_ofs(9'h002);
        settle();
        chk("R1 load mode held", {8'd0, empty_n}, 9'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule